// File: doc/BRIEF.md
# DRAM Init and Refresh Sequencer

This block brings a DRAM array out of power-up and then keeps it refreshed on behalf of the access controller that sits above it. Once reset is released it stays quiet for a programmable start-up delay and then runs a fixed burst of initialization refresh cycles. After that burst it raises `ready`, and from then on it produces one refresh per fixed interval.

Every refresh is a CAS-before-RAS cycle. The column strobe goes low first, the row strobe follows, and both stay low together for a set time before a precharge gap. Write enable stays high for the whole cycle. A low write enable at that point would put the array into its test mode, and a plain CAS-before-RAS cycle also clears any test mode that was entered by mistake. The block asks the access controller for the bus through `req`, drives the strobes only while it holds `grant`, and then lowers `req` for at least one cycle.

The interval timer keeps counting while a request waits for the grant. Refreshes that have not yet been served add up in a bounded counter. When that counter is full, `urgent` rises so the controller can stop postponing. Once the grant comes back, the queued refreshes run back to back.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `req` and `ready` are low and `urgent` is low. `rasN`, `casN` and `weN` are high (strobes idle, active-low).
- R2: After reset is released, `req` stays low and neither strobe moves for at least `STARTUP_CYC` cycles. With the registered outputs, `req` first rises at the clock edge numbered `STARTUP_CYC`+2 after release.
- R3: Exactly `INIT_REFRESHES` refresh cycles (falling edges of `rasN`) complete before `ready` rises. Once high, `ready` stays high until the next reset.
- R4: In each refresh, `casN` is low for at least `CAS_LEAD_CYC` cycles before `rasN` falls. `rasN` is then low for exactly `RAS_LOW_CYC` cycles with `casN` low the whole time. Both strobes are then high for at least `PRECHARGE_CYC` cycles before `casN` falls again.
- R5: `weN` is high in every cycle, including the cycles around each fall of `rasN`.
- R6: A strobe is low only while both `req` and `grant` are high. After each refresh, `req` goes low for at least one cycle. While `grant` is withheld, no strobe moves.
- R7: After `ready`, the block produces one refresh per `REFRESH_INTERVAL` cycles on average. A window of ten intervals holds 10±1 refreshes.
- R8: The interval timer keeps running while the grant is withheld. Postponed refreshes queue up to `MAX_PENDING`, and further interval ticks are dropped. `urgent` is high exactly while the queue is full. When the grant returns, the queued refreshes (plus at most one new tick) run back to back.
- R9: `urgent` drops once the queue falls below `MAX_PENDING`. `urgent` never rises before `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Bus granted to this block by the access controller; held while `req` is high |
| req | output | 1 | Bus request to the access controller |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low; held high |
| ready | output | 1 | Initialization burst complete; normal access allowed |
| urgent | output | 1 | Postponed-refresh queue is full |

## Verification
The grant is driven in three ways:
- **Random grant latency (0 to 3 cycles).** Used during the start-up delay, the initialization burst and a ten-interval rate window. It shows that the strobe order and widths do not depend on when the grant arrives, and that the refresh count tracks the interval timer.
- **Grant withheld for several intervals.** This separates a timer that keeps running from one that stalls, and a saturating queue from an unbounded one.
- **Immediate grant.** This drains the queue back to back, so the number of refreshes it yields shows how many were kept.

A reset in mid-operation checks that the block returns to its idle state.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // which timed step of a refresh cycle the shared phase timer is measuring
  typedef enum logic [1:0] {
    PH_LEAD    = 2'd0,
    PH_STROBE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    ST_POWERUP   = 3'd0,
    ST_IDLE      = 3'd1,
    ST_CAS_LEAD  = 3'd2,
    ST_RAS_LOW   = 3'd3,
    ST_PRECHARGE = 3'd4,
    ST_RELEASE   = 3'd5
  } seq_state_e;

  // control -> datapath
  typedef struct packed {
    logic   reqOn;
    logic   casOn;
    logic   rasOn;
    logic   phaseRun;
    phase_e phaseSel;
    logic   useInit;
    logic   usePending;
  } seq_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic startupDone;
    logic phaseDone;
    logic initLeft;
    logic pendingAny;
  } seq_status_t;

endpackage

// File: rtl/refresh_seq_datapath.sv
module refresh_seq_datapath
  import dram_refresh_pkg::*;
#(
  parameter int STARTUP_CYC      = 20000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REFRESH_INTERVAL = 1560,
  parameter int MAX_PENDING      = 8,
  parameter int CAS_LEAD_CYC     = 1,
  parameter int RAS_LOW_CYC      = 6,
  parameter int PRECHARGE_CYC    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  output seq_status_t status,
  output logic        req,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        ready,
  output logic        urgent
);

  localparam int START_W = (STARTUP_CYC < 1) ? 1 : $clog2(STARTUP_CYC + 1);
  localparam int INIT_W  = $clog2(INIT_REFRESHES + 1) < 1 ? 1 : $clog2(INIT_REFRESHES + 1);
  localparam int INT_W   = $clog2(REFRESH_INTERVAL);
  localparam int PEND_W  = $clog2(MAX_PENDING + 1);
  localparam int PH_MAX_A = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int PH_MAX   = (PH_MAX_A > PRECHARGE_CYC) ? PH_MAX_A : PRECHARGE_CYC;
  localparam int PH_W     = $clog2(PH_MAX + 1);

  // ---------------- start-up delay ----------------
  logic startupDone;
  generate
    if (STARTUP_CYC == 0) begin : g_noDelay
      assign startupDone = 1'b1;
    end else begin : g_delay
      logic [START_W-1:0] startCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               startCnt <= '0;
        else if (startCnt != START_W'(STARTUP_CYC)) startCnt <= startCnt + 1'b1;
      end
      assign startupDone = (startCnt == START_W'(STARTUP_CYC));
    end
  endgenerate

  // ---------------- initialization burst count ----------------
  logic [INIT_W-1:0] initCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              initCnt <= INIT_W'(INIT_REFRESHES);
    else if (strobe.useInit && initCnt != '0) initCnt <= initCnt - 1'b1;
  end
  assign ready = (initCnt == '0);

  // ---------------- refresh interval timer ----------------
  logic [INT_W-1:0] intCnt;
  logic             intTick;
  assign intTick = ready && (intCnt == INT_W'(REFRESH_INTERVAL - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        intCnt <= '0;
    else if (!ready)  intCnt <= '0;
    else if (intTick) intCnt <= '0;
    else              intCnt <= intCnt + 1'b1;
  end

  // ---------------- postponed-refresh queue ----------------
  logic [PEND_W-1:0] pendCnt;
  logic              pendFull, addOne, subOne;
  assign pendFull = (pendCnt == PEND_W'(MAX_PENDING));
  assign subOne   = strobe.usePending && (pendCnt != '0);
  assign addOne   = intTick && (!pendFull || subOne);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else begin
      case ({addOne, subOne})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end
  assign urgent = pendFull;

  // ---------------- shared phase timer ----------------
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLast;
  logic            phaseDone;
  always_comb begin
    case (strobe.phaseSel)
      PH_LEAD:    phaseLast = PH_W'(CAS_LEAD_CYC - 1);
      PH_STROBE:  phaseLast = PH_W'(RAS_LOW_CYC - 1);
      default:    phaseLast = PH_W'(PRECHARGE_CYC - 1);
    endcase
  end
  assign phaseDone = strobe.phaseRun && (phaseCnt == phaseLast);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            phaseCnt <= '0;
    else if (!strobe.phaseRun || phaseDone) phaseCnt <= '0;
    else                                  phaseCnt <= phaseCnt + 1'b1;
  end

  // ---------------- registered pin drivers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      req  <= 1'b0;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
    end else begin
      req  <= strobe.reqOn;
      rasN <= ~strobe.rasOn;
      casN <= ~strobe.casOn;
      weN  <= 1'b1;  // low here would select the array's test mode
    end
  end

  assign status.startupDone = startupDone;
  assign status.phaseDone   = phaseDone;
  assign status.initLeft    = ~ready;
  assign status.pendingAny  = (pendCnt != '0);

endmodule

// File: rtl/refresh_seq_control.sv
module refresh_seq_control
  import dram_refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grant,
  input  seq_status_t status,
  output seq_strobe_t strobe
);

  seq_state_e state, stateNext;
  logic       work;

  assign work = status.initLeft || status.pendingAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_POWERUP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_POWERUP: begin
        if (status.startupDone) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        strobe.reqOn = work;
        if (work && grant) stateNext = ST_CAS_LEAD;
      end
      ST_CAS_LEAD: begin
        strobe.reqOn    = 1'b1;
        strobe.casOn    = 1'b1;
        strobe.phaseRun = 1'b1;
        strobe.phaseSel = PH_LEAD;
        if (status.phaseDone) stateNext = ST_RAS_LOW;
      end
      ST_RAS_LOW: begin
        strobe.reqOn    = 1'b1;
        strobe.casOn    = 1'b1;
        strobe.rasOn    = 1'b1;
        strobe.phaseRun = 1'b1;
        strobe.phaseSel = PH_STROBE;
        if (status.phaseDone) stateNext = ST_PRECHARGE;
      end
      ST_PRECHARGE: begin
        strobe.reqOn    = 1'b1;
        strobe.phaseRun = 1'b1;
        strobe.phaseSel = PH_RECOVER;
        if (status.phaseDone) begin
          strobe.useInit    = status.initLeft;
          strobe.usePending = ~status.initLeft;
          stateNext         = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        stateNext = ST_IDLE;  // one cycle with the request dropped
      end
      default: stateNext = ST_POWERUP;
    endcase
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int STARTUP_CYC      = 20000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REFRESH_INTERVAL = 1560,
  parameter int MAX_PENDING      = 8,
  parameter int CAS_LEAD_CYC     = 1,
  parameter int RAS_LOW_CYC      = 6,
  parameter int PRECHARGE_CYC    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic grant,
  output logic req,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic ready,
  output logic urgent
);

  seq_strobe_t strobe;
  seq_status_t status;

  refresh_seq_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .grant  (grant),
    .status (status),
    .strobe (strobe)
  );

  refresh_seq_datapath #(
    .STARTUP_CYC      (STARTUP_CYC),
    .INIT_REFRESHES   (INIT_REFRESHES),
    .REFRESH_INTERVAL (REFRESH_INTERVAL),
    .MAX_PENDING      (MAX_PENDING),
    .CAS_LEAD_CYC     (CAS_LEAD_CYC),
    .RAS_LOW_CYC      (RAS_LOW_CYC),
    .PRECHARGE_CYC    (PRECHARGE_CYC)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status),
    .req    (req),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .ready  (ready),
    .urgent (urgent)
  );

endmodule

// File: rtl/refresh_seq_checks.sv
module refresh_seq_checks #(
  parameter int STARTUP_CYC = 20000
) (
  input logic clk,
  input logic rstN,
  input logic grant,
  input logic req,
  input logic rasN,
  input logic casN,
  input logic ready,
  input logic urgent
);

  logic [31:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           sinceReset <= '0;
    else if (sinceReset < STARTUP_CYC)   sinceReset <= sinceReset + 1;
  end

  AST_QUIET_STARTUP: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset < STARTUP_CYC) |-> (!req && rasN && casN));                 // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);                                                       // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));                               // R4
  AST_RAS_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);                                                       // R4
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> (req && grant));                                   // R6
  AST_URGENT_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    urgent |-> ready);                                                      // R9

endmodule

bind dram_refresh_seq refresh_seq_checks #(.STARTUP_CYC(STARTUP_CYC)) u_checks (
  .clk    (clk),
  .rstN   (rstN),
  .grant  (grant),
  .req    (req),
  .rasN   (rasN),
  .casN   (casN),
  .ready  (ready),
  .urgent (urgent)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_START = 60;
  localparam int P_INIT  = 8;
  localparam int P_INT   = 100;
  localparam int P_MAXP  = 4;
  localparam int P_CSR   = 1;
  localparam int P_RAS   = 3;
  localparam int P_RP    = 2;

  logic clk, rstN, grant;
  logic req, rasN, casN, weN, ready, urgent;

  dram_refresh_seq #(
    .STARTUP_CYC(P_START), .INIT_REFRESHES(P_INIT), .REFRESH_INTERVAL(P_INT),
    .MAX_PENDING(P_MAXP), .CAS_LEAD_CYC(P_CSR), .RAS_LOW_CYC(P_RAS),
    .PRECHARGE_CYC(P_RP)
  ) uut (
    .clk(clk), .rstN(rstN), .grant(grant), .req(req), .rasN(rasN),
    .casN(casN), .weN(weN), .ready(ready), .urgent(urgent)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic int expFirstReq(int startup);
    return startup + 2;
  endfunction
  function automatic int expQueued(int ticks, int limit);
    return (ticks > limit) ? limit : ticks;
  endfunction

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // ---------------- grant model ----------------
  int grantMode = 0;  // 0 random latency, 1 withheld, 2 immediate
  int grantWait = 0;
  always begin
    @(posedge clk);
    #2;
    if (!rstN || !req) begin
      grant = 1'b0;
      grantWait = int'($urandom_range(0, 3));
    end else if (!grant) begin
      if (grantMode == 2) grant = 1'b1;
      else if (grantMode == 0) begin
        if (grantWait == 0) grant = 1'b1;
        else grantWait--;
      end
    end
  end

  // ---------------- pin monitor ----------------
  int  cycSinceRst = 0;
  int  firstReq = -1;
  int  rasFalls = 0;
  int  casLowRun = 0, rasLowRun = 0, idleRun = 100;
  bit  casHeld = 1'b1;
  bit  prevRas = 1'b1, prevCas = 1'b1;
  bit  ownFlag = 1'b0, weFlag = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      cycSinceRst = 0; firstReq = -1;
      prevRas = 1'b1; prevCas = 1'b1;
      casLowRun = 0; rasLowRun = 0; idleRun = 100;
    end else begin
      cycSinceRst++;
      if (req && firstReq < 0) firstReq = cycSinceRst;
      if (!weN && !weFlag) begin
        weFlag = 1'b1;
        check(1'b0, "R5 weN low", 0, 1);
      end
      if ((!rasN || !casN) && !(req && grant) && !ownFlag) begin
        ownFlag = 1'b1;
        check(1'b0, "R6 strobe without ownership", int'(req && grant), 1);
      end
      if (prevRas && !rasN) begin
        rasFalls++;
        check(casLowRun >= P_CSR, "R4 cas lead", casLowRun, P_CSR);
        check(weN == 1'b1, "R5 weN at ras fall", int'(weN), 1);
        check(req && grant, "R6 owned at ras fall", int'(req && grant), 1);
        casHeld = 1'b1;
      end
      if (!prevRas && rasN) begin
        check(rasLowRun == P_RAS && casHeld, "R4 ras width with cas held",
              rasLowRun, P_RAS);
      end
      if (prevCas && !casN)
        check(idleRun >= P_RP, "R4 precharge", idleRun, P_RP);
      if (!rasN && casN) casHeld = 1'b0;
      casLowRun = casN ? 0 : casLowRun + 1;
      rasLowRun = rasN ? 0 : rasLowRun + 1;
      idleRun   = (rasN && casN) ? idleRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitIdle();
    int lowRun = 0;
    while (lowRun < 3) begin
      step(1);
      lowRun = req ? 0 : lowRun + 1;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int base, drained, held;
    void'($urandom(32'h1d5e_ed07));
    rstN = 1'b0;
    grant = 1'b0;
    step(3);
    // R1 reset state
    check(req == 0 && ready == 0 && urgent == 0, "R1 reset req/ready/urgent",
          int'({req, ready, urgent}), 0);
    check(rasN && casN && weN, "R1 reset strobes idle", int'({rasN, casN, weN}), 7);

    @(negedge clk); #2 rstN = 1'b1;

    // R2 start-up delay then R3 initialization burst
    while (!ready) step(1);
    check(firstReq == expFirstReq(P_START), "R2 first request cycle",
          firstReq, expFirstReq(P_START));
    check(rasFalls == P_INIT, "R3 init refresh count", rasFalls, P_INIT);
    check(urgent == 0, "R9 urgent low at ready", int'(urgent), 0);

    // R7 steady rate with random grant latency
    waitIdle();
    base = rasFalls;
    step(10 * P_INT);
    check(rasFalls - base >= 9 && rasFalls - base <= 11, "R7 refresh rate",
          rasFalls - base, 10);
    check(ready == 1, "R3 ready sticky", int'(ready), 1);

    // R8 grant withheld: queue builds, no strobes, urgent when full
    waitIdle();
    grantMode = 1;
    base = rasFalls;
    step((P_MAXP - 1) * P_INT - 2);
    check(urgent == 0, "R8 urgent not before queue full", int'(urgent), 0);
    check(req == 1, "R8 request waits for grant", int'(req), 1);
    step(2 * P_INT + 2);
    check(urgent == 1, "R8 urgent when queue full", int'(urgent), 1);
    check(rasFalls == base, "R6 no strobes while withheld", rasFalls - base, 0);
    step(2 * P_INT);
    held = P_MAXP + 3;
    check(urgent == 1 && rasFalls == base, "R8 saturated queue holds",
          rasFalls - base, 0);

    // drain with immediate grant
    grantMode = 2;
    waitIdle();
    drained = rasFalls - base;
    check(drained == expQueued(held, P_MAXP) || drained == expQueued(held, P_MAXP) + 1,
          "R8 drained postponed refreshes", drained, expQueued(held, P_MAXP));
    check(urgent == 0, "R9 urgent clears after drain", int'(urgent), 0);

    // directed: steady run with immediate grant
    base = rasFalls;
    step(3 * P_INT);
    check(rasFalls - base >= 2 && rasFalls - base <= 4, "R7 rate immediate grant",
          rasFalls - base, 3);

    // R1 reset in mid-operation
    grantMode = 0;
    step(17);
    #1 rstN = 1'b0;
    step(1);
    check(req == 0 && ready == 0 && urgent == 0, "R1 mid-run reset outputs",
          int'({req, ready, urgent}), 0);
    check(rasN && casN && weN, "R1 mid-run reset strobes", int'({rasN, casN, weN}), 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule